// File: doc/BRIEF.md
# Memory Region Protection Rule Checker

This block decides, for each memory transaction, whether it is accepted or rejected. The decision comes from a table of programmable protection rules. Each rule describes an address window with a granularity of 1 MiB, an inclusive range of master protection IDs, a two-bit security qualifier, a mask of the ports it applies to, a valid flag and a result bit. When no rule claims a transaction, a per-port default register gives the outcome.

Software never addresses the rule table directly. It fills three staging registers (address window, ID range, rule data) and then writes a command register that names a rule. The command either copies the staging registers into that rule or loads that rule back into the staging registers, where software can read it. Register writes take effect on the clock edge. Register reads and transaction decisions are combinational.

Top module: `prot_checker`

## Requirements
- R1: After reset every register reads zero and the table is empty, so every transaction on a legal port is accepted with no rule hit.
- R2: A write to the command register (offset 0) with bit 5 set copies the staging registers into the rule whose number is in bits [4:0]. Reading offset 0 returns the last rule number written.
- R3: A write to the command register with bit 6 set and bit 5 clear loads the selected rule into the staging registers. The loaded rule can be read back from the staging registers on the next cycle.
- R4: Staging field layout. Address staging (offset 1) holds the low bound in [11:0] and the high bound in [23:12]. ID staging (offset 2) holds the low ID in [11:0] and the high ID in [23:12]. Data staging (offset 3) holds security in [1:0], valid in bit 2, the port mask in [12:3] and the result in bit 13. The default register (offset 4) is 10 bits wide. All unused bits read zero.
- R5: A rule's address test passes only when transaction address bits [31:20] lie between the low and high bounds, both bounds included.
- R6: A rule's ID test passes only when the transaction ID lies between the low and high IDs, both included.
- R7: Security bit 0 admits secure transactions (txn_nonsec_i=0) and bit 1 admits non-secure ones (txn_nonsec_i=1). A rule with security 0 never matches.
- R8: A rule matches only transactions whose port number selects a set bit in its port mask.
- R9: When several valid rules match, the lowest-numbered one decides, and that number is reported.
- R10: A matching rule with result 0 accepts the transaction. A result of 1 rejects it.
- R11: With no matching rule, the transaction is rejected if its port's bit in the default register is 1 and accepted if it is 0. A port number of 10 or above is always rejected.
- R12: A rule with valid clear never matches. Writing an all-zero staging set into a rule clears it.
- R13: A command naming a rule number of 20 or above changes neither the table nor the staging registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| txn_addr_i | input | 32 | Transaction byte address |
| txn_id_i | input | 12 | Transaction master protection ID |
| txn_port_i | input | 4 | Transaction port number |
| txn_nonsec_i | input | 1 | Transaction is non-secure |
| txn_accept_o | output | 1 | Transaction accepted |
| txn_hit_o | output | 1 | A rule matched |
| txn_rule_o | output | 5 | Number of the deciding rule |

## Verification
Every register write, including both command copies, lands on the rising edge at the end of the cycle in which it is presented. The new state is therefore visible on reg_rdata_o and on the transaction outputs in the very next cycle. Reads and transaction decisions depend on the current inputs only, with no pipeline delay. The bench drives all inputs on the falling edge and holds a write for exactly one rising edge. It samples the combinational outputs 1 ns after it sets the inputs, well clear of any edge, so each check sees the state left by the preceding write.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int BND_W  = 12;
  localparam int PID_W  = 12;
  localparam int SEC_W  = 2;
  localparam int MASK_W = 10;
  localparam int PORT_W = $clog2(MASK_W);
  localparam int CMD_WR = 5;
  localparam int CMD_RD = 6;

  localparam logic [2:0] OFS_CMD  = 3'd0;
  localparam logic [2:0] OFS_ADDR = 3'd1;
  localparam logic [2:0] OFS_ID   = 3'd2;
  localparam logic [2:0] OFS_DATA = 3'd3;
  localparam logic [2:0] OFS_DFLT = 3'd4;

  typedef struct packed {
    logic [BND_W-1:0]  lo_bnd;
    logic [BND_W-1:0]  hi_bnd;
    logic [PID_W-1:0]  lo_id;
    logic [PID_W-1:0]  hi_id;
    logic [SEC_W-1:0]  sec;
    logic              vld;
    logic [MASK_W-1:0] mask;
    logic              res;
  } rule_t;
endpackage

// File: rtl/prot_regs.sv
module prot_regs
  import prot_pkg::*;
#(
  parameter int NUM_RULES = 20,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_RULES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  rule_t             rd_rule_i,
  output logic [IDX_W-1:0]  tbl_idx_o,
  output logic              tbl_we_o,
  output rule_t             stage_o,
  output logic [MASK_W-1:0] dflt_o
);
  rule_t             stage_q;
  logic [IDX_W-1:0]  sel_q;
  logic [MASK_W-1:0] dflt_q;
  logic              cmd_hit, idx_ok, load;
  logic [IDX_W-1:0]  cmd_idx;

  assign cmd_hit   = reg_we_i && (reg_addr_i == OFS_CMD);
  assign cmd_idx   = reg_wdata_i[IDX_W-1:0];
  assign idx_ok    = 32'(cmd_idx) < NUM_RULES;
  assign tbl_idx_o = cmd_idx;
  assign tbl_we_o  = cmd_hit && reg_wdata_i[CMD_WR] && idx_ok;
  // write wins when both command bits are set
  assign load      = cmd_hit && reg_wdata_i[CMD_RD] && !reg_wdata_i[CMD_WR] && idx_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      sel_q   <= '0;
      dflt_q  <= '0;
    end else if (load) begin
      stage_q <= rd_rule_i;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        OFS_CMD:  sel_q <= cmd_idx;
        OFS_ADDR: begin
          stage_q.lo_bnd <= reg_wdata_i[BND_W-1:0];
          stage_q.hi_bnd <= reg_wdata_i[2*BND_W-1:BND_W];
        end
        OFS_ID: begin
          stage_q.lo_id <= reg_wdata_i[PID_W-1:0];
          stage_q.hi_id <= reg_wdata_i[2*PID_W-1:PID_W];
        end
        OFS_DATA: begin
          stage_q.sec  <= reg_wdata_i[SEC_W-1:0];
          stage_q.vld  <= reg_wdata_i[SEC_W];
          stage_q.mask <= reg_wdata_i[SEC_W+MASK_W:SEC_W+1];
          stage_q.res  <= reg_wdata_i[SEC_W+MASK_W+1];
        end
        OFS_DFLT: dflt_q <= reg_wdata_i[MASK_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      OFS_CMD:  reg_rdata_o = DATA_W'(sel_q);
      OFS_ADDR: reg_rdata_o = DATA_W'({stage_q.hi_bnd, stage_q.lo_bnd});
      OFS_ID:   reg_rdata_o = DATA_W'({stage_q.hi_id, stage_q.lo_id});
      OFS_DATA: reg_rdata_o = DATA_W'({stage_q.res, stage_q.mask, stage_q.vld, stage_q.sec});
      OFS_DFLT: reg_rdata_o = DATA_W'(dflt_q);
      default:  reg_rdata_o = '0;
    endcase
  end

  assign stage_o = stage_q;
  assign dflt_o  = dflt_q;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i[DATA_W-1:2*BND_W];

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (stage_q == $past(rd_rule_i)))
    else $error("load did not copy rule into staging");

  p_bad_idx_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_hit && !idx_ok) |=> $stable(stage_q))
    else $error("out-of-range command touched staging");
endmodule

// File: rtl/prot_rule_table.sv
module prot_rule_table
  import prot_pkg::*;
#(
  parameter int NUM_RULES = 20,
  localparam int IDX_W    = $clog2(NUM_RULES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  rule_t            wdata_i,
  output rule_t            rd_o,
  output rule_t            rules_o [NUM_RULES]
);
  for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
    rule_t rule_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          rule_q <= '0;
      else if (we_i && idx_i == IDX_W'(g)) rule_q <= wdata_i;
    end
    assign rules_o[g] = rule_q;

    p_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && idx_i == IDX_W'(g)) |=> (rule_q == $past(wdata_i)))
      else $error("rule %0d not written", g);
  end

  always_comb begin
    rd_o = '0;
    for (int i = 0; i < NUM_RULES; i++)
      if (idx_i == IDX_W'(i)) rd_o = rules_o[i];
  end
endmodule

// File: rtl/prot_match.sv
module prot_match
  import prot_pkg::*;
#(
  parameter int NUM_RULES = 20,
  parameter int ADDR_W    = 32,
  localparam int IDX_W    = $clog2(NUM_RULES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rule_t             rules_i [NUM_RULES],
  input  logic [MASK_W-1:0] dflt_i,
  input  logic [ADDR_W-1:0] txn_addr_i,
  input  logic [PID_W-1:0]  txn_id_i,
  input  logic [PORT_W-1:0] txn_port_i,
  input  logic              txn_nonsec_i,
  output logic              txn_accept_o,
  output logic              txn_hit_o,
  output logic [IDX_W-1:0]  txn_rule_o
);
  logic [BND_W-1:0]     blk;
  logic                 port_ok;
  logic [NUM_RULES-1:0] hit_vec;

  assign blk     = txn_addr_i[ADDR_W-1:ADDR_W-BND_W];
  assign port_ok = 32'(txn_port_i) < MASK_W;

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_cmp
    logic in_win, in_ids, sec_ok, on_port;
    assign in_win  = (blk >= rules_i[g].lo_bnd) && (blk <= rules_i[g].hi_bnd);
    assign in_ids  = (txn_id_i >= rules_i[g].lo_id) && (txn_id_i <= rules_i[g].hi_id);
    assign sec_ok  = rules_i[g].sec[txn_nonsec_i];
    assign on_port = port_ok && rules_i[g].mask[txn_port_i];
    assign hit_vec[g] = rules_i[g].vld && in_win && in_ids && sec_ok && on_port;
  end

  // lowest index wins
  always_comb begin
    txn_hit_o  = 1'b0;
    txn_rule_o = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        txn_hit_o  = 1'b1;
        txn_rule_o = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (!port_ok)       txn_accept_o = 1'b0;
    else if (txn_hit_o) txn_accept_o = !rules_i[txn_rule_o].res;
    else                txn_accept_o = !dflt_i[txn_port_i];
  end

  logic unused_addr;
  assign unused_addr = ^txn_addr_i[ADDR_W-BND_W-1:0];

  p_lowest_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_hit_o |-> ((hit_vec & ((NUM_RULES'(1) << txn_rule_o) - NUM_RULES'(1))) == '0))
    else $error("a lower rule also matched");

  p_hit_valid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_hit_o |-> rules_i[txn_rule_o].vld)
    else $error("hit reported on an invalid rule");

  p_bad_port_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_ok |-> (!txn_accept_o && !txn_hit_o))
    else $error("illegal port not rejected");
endmodule

// File: rtl/prot_checker.sv
module prot_checker
  import prot_pkg::*;
#(
  parameter int NUM_RULES = 20,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_RULES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [ADDR_W-1:0] txn_addr_i,
  input  logic [PID_W-1:0]  txn_id_i,
  input  logic [PORT_W-1:0] txn_port_i,
  input  logic              txn_nonsec_i,
  output logic              txn_accept_o,
  output logic              txn_hit_o,
  output logic [IDX_W-1:0]  txn_rule_o
);
  rule_t             rd_rule, stage;
  rule_t             rules [NUM_RULES];
  logic [IDX_W-1:0]  tbl_idx;
  logic              tbl_we;
  logic [MASK_W-1:0] dflt;

  prot_regs #(.NUM_RULES(NUM_RULES), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .rd_rule_i(rd_rule), .tbl_idx_o(tbl_idx), .tbl_we_o(tbl_we),
    .stage_o(stage), .dflt_o(dflt)
  );

  prot_rule_table #(.NUM_RULES(NUM_RULES)) u_table (
    .clk_i, .rst_ni, .we_i(tbl_we), .idx_i(tbl_idx), .wdata_i(stage),
    .rd_o(rd_rule), .rules_o(rules)
  );

  prot_match #(.NUM_RULES(NUM_RULES), .ADDR_W(ADDR_W)) u_match (
    .clk_i, .rst_ni, .rules_i(rules), .dflt_i(dflt), .txn_addr_i, .txn_id_i,
    .txn_port_i, .txn_nonsec_i, .txn_accept_o, .txn_hit_o, .txn_rule_o
  );

  p_default_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!txn_hit_o && 32'(txn_port_i) < MASK_W && dflt == '0) |-> txn_accept_o)
    else $error("unmatched traffic rejected with zero default");
endmodule

// File: tb/prot_checker_tb.sv
module prot_checker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] txn_addr = '0;
  logic [11:0] txn_id = '0;
  logic [3:0]  txn_port = '0;
  logic        txn_nonsec = 1'b0;
  logic        txn_accept, txn_hit;
  logic [4:0]  txn_rule;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  prot_checker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .txn_addr_i(txn_addr),
    .txn_id_i(txn_id), .txn_port_i(txn_port), .txn_nonsec_i(txn_nonsec),
    .txn_accept_o(txn_accept), .txn_hit_o(txn_hit), .txn_rule_o(txn_rule)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic prog(int idx, int lo, int hi, int loid, int hiid,
                      int sec, int vld, int mask, int res);
    wr(3'd1, 32'(lo) | (32'(hi) << 12));
    wr(3'd2, 32'(loid) | (32'(hiid) << 12));
    wr(3'd3, 32'(sec) | (32'(vld) << 2) | (32'(mask) << 3) | (32'(res) << 13));
    wr(3'd0, 32'(idx) | 32'h20);
  endtask

  task automatic clear_all();
    wr(3'd1, 0); wr(3'd2, 0); wr(3'd3, 0);
    for (int i = 0; i < 20; i++) wr(3'd0, 32'(i) | 32'h20);
    wr(3'd4, 0);
  endtask

  task automatic txn(string req, logic [31:0] a, logic [11:0] id, logic [3:0] p,
                     logic ns, logic acc, logic hit, logic [4:0] rule);
    txn_addr = a; txn_id = id; txn_port = p; txn_nonsec = ns; #1;
    chk({req, " accept"}, 32'(txn_accept), 32'(acc));
    chk({req, " hit"}, 32'(txn_hit), 32'(hit));
    if (hit) chk({req, " rule"}, 32'(txn_rule), 32'(rule));
  endtask

  task automatic t_reset();
    for (int a = 0; a < 5; a++) rd_chk("R1 reg reset", 3'(a), 0);
    txn("R1", 32'hFFF0_0000, 12'hABC, 4'd9, 1'b1, 1'b1, 1'b0, 0);
    txn("R1", 32'h0, 12'h0, 4'd0, 1'b0, 1'b1, 1'b0, 0);
  endtask

  task automatic t_fields();
    wr(3'd1, 32'hFFFF_FFFF); rd_chk("R4 addr stage", 3'd1, 32'h00FF_FFFF);
    wr(3'd2, 32'hFFFF_FFFF); rd_chk("R4 id stage", 3'd2, 32'h00FF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF); rd_chk("R4 data stage", 3'd3, 32'h0000_3FFF);
    wr(3'd4, 32'hFFFF_FFFF); rd_chk("R4 default", 3'd4, 32'h0000_03FF);
    wr(3'd5, 32'hFFFF_FFFF); rd_chk("R4 unused offset", 3'd5, 0);
    clear_all();
  endtask

  task automatic t_wr_rd();
    prog(7, 12'h123, 12'h456, 12'h0AB, 12'hCDE, 2, 1, 10'h2A5, 1);
    rd_chk("R2 cmd readback", 3'd0, 7);
    wr(3'd1, 0); wr(3'd2, 0); wr(3'd3, 0);
    wr(3'd0, 32'd7 | 32'h40);
    rd_chk("R3 load addr", 3'd1, 32'h0045_6123);
    rd_chk("R3 load id", 3'd2, 32'h00CD_E0AB);
    rd_chk("R3 load data", 3'd3, 32'h2 | (32'h1 << 2) | (32'h2A5 << 3) | (32'h1 << 13));
    // port 0 is set in 0x2A5, window blocks 0x123..0x456, non-secure allowed
    txn("R2 written rule active", 32'h1230_0000, 12'h0AB, 4'd0, 1'b1, 1'b0, 1'b1, 7);
    clear_all();
  endtask

  task automatic t_addr();
    prog(0, 2, 5, 0, 12'hFFF, 3, 1, 10'h3FF, 1);
    txn("R5 low bound", 32'h0020_0000, 0, 0, 0, 1'b0, 1'b1, 0);
    txn("R5 high bound", 32'h005F_FFFF, 0, 0, 0, 1'b0, 1'b1, 0);
    txn("R5 above", 32'h0060_0000, 0, 0, 0, 1'b1, 1'b0, 0);
    txn("R5 below", 32'h001F_FFFF, 0, 0, 0, 1'b1, 1'b0, 0);
    clear_all();
  endtask

  task automatic t_id();
    prog(3, 0, 12'hFFF, 12'h010, 12'h020, 3, 1, 10'h3FF, 1);
    txn("R6 low id", 32'h0, 12'h010, 0, 0, 1'b0, 1'b1, 3);
    txn("R6 high id", 32'h0, 12'h020, 0, 0, 1'b0, 1'b1, 3);
    txn("R6 above", 32'h0, 12'h021, 0, 0, 1'b1, 1'b0, 0);
    txn("R6 below", 32'h0, 12'h00F, 0, 0, 1'b1, 1'b0, 0);
    clear_all();
  endtask

  task automatic t_sec();
    prog(3, 0, 12'hFFF, 0, 12'hFFF, 1, 1, 10'h3FF, 1);
    txn("R7 sec1 secure", 32'h0, 0, 0, 1'b0, 1'b0, 1'b1, 3);
    txn("R7 sec1 nonsec", 32'h0, 0, 0, 1'b1, 1'b1, 1'b0, 0);
    prog(3, 0, 12'hFFF, 0, 12'hFFF, 2, 1, 10'h3FF, 1);
    txn("R7 sec2 secure", 32'h0, 0, 0, 1'b0, 1'b1, 1'b0, 0);
    txn("R7 sec2 nonsec", 32'h0, 0, 0, 1'b1, 1'b0, 1'b1, 3);
    prog(3, 0, 12'hFFF, 0, 12'hFFF, 0, 1, 10'h3FF, 1);
    txn("R7 sec0 secure", 32'h0, 0, 0, 1'b0, 1'b1, 1'b0, 0);
    txn("R7 sec0 nonsec", 32'h0, 0, 0, 1'b1, 1'b1, 1'b0, 0);
    clear_all();
  endtask

  task automatic t_port();
    prog(1, 0, 12'hFFF, 0, 12'hFFF, 3, 1, 10'h004, 1);
    txn("R8 port in mask", 32'h0, 0, 4'd2, 0, 1'b0, 1'b1, 1);
    txn("R8 port outside", 32'h0, 0, 4'd3, 0, 1'b1, 1'b0, 0);
    clear_all();
  endtask

  task automatic t_prio();
    prog(4, 0, 12'hFFF, 0, 12'hFFF, 3, 1, 10'h3FF, 0);
    prog(2, 0, 12'hFFF, 0, 12'hFFF, 3, 1, 10'h3FF, 1);
    txn("R9 lowest wins", 32'h8000_0000, 12'h5, 4'd6, 0, 1'b0, 1'b1, 2);
    prog(2, 0, 0, 0, 0, 0, 0, 0, 0);
    txn("R10 result 0 accepts", 32'h8000_0000, 12'h5, 4'd6, 0, 1'b1, 1'b1, 4);
    clear_all();
  endtask

  task automatic t_default();
    wr(3'd4, 32'h3FF);
    txn("R11 default reject", 32'h0, 0, 4'd0, 0, 1'b0, 1'b0, 0);
    wr(3'd4, 32'h001);
    txn("R11 port0 reject", 32'h0, 0, 4'd0, 0, 1'b0, 1'b0, 0);
    txn("R11 port1 accept", 32'h0, 0, 4'd1, 0, 1'b1, 1'b0, 0);
    wr(3'd4, 0);
    txn("R11 illegal port", 32'h0, 0, 4'd12, 0, 1'b0, 1'b0, 0);
  endtask

  task automatic t_invalid();
    prog(0, 0, 12'hFFF, 0, 12'hFFF, 3, 0, 10'h3FF, 1);
    txn("R12 invalid ignored", 32'h0, 0, 0, 0, 1'b1, 1'b0, 0);
    prog(5, 0, 12'hFFF, 0, 12'hFFF, 3, 1, 10'h3FF, 1);
    txn("R12 before clear", 32'h0, 0, 0, 0, 1'b0, 1'b1, 5);
    prog(5, 0, 0, 0, 0, 0, 0, 0, 0);
    txn("R12 cleared", 32'h0, 0, 0, 0, 1'b1, 1'b0, 0);
    wr(3'd3, 32'h3FFF);
    wr(3'd0, 32'd5 | 32'h40);
    rd_chk("R12 cleared readback", 3'd3, 0);
    clear_all();
  endtask

  task automatic t_range();
    wr(3'd1, 32'h00FF_F000); wr(3'd2, 32'h00FF_F000);
    wr(3'd3, 32'h3 | 32'h4 | (32'h3FF << 3) | (32'h1 << 13));
    wr(3'd0, 32'd25 | 32'h20);
    txn("R13 write ignored", 32'h0, 0, 0, 0, 1'b1, 1'b0, 0);
    wr(3'd0, 32'd25 | 32'h40);
    rd_chk("R13 load ignored addr", 3'd1, 32'h00FF_F000);
    rd_chk("R13 load ignored data", 3'd3, 32'h3FFF);
    clear_all();
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_wr_rd();
    t_addr();
    t_id();
    t_sec();
    t_port();
    t_prio();
    t_default();
    t_invalid();
    t_range();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule